// File: doc/BRIEF.md
# DDR Write Strobe Lane Sequencer

This block produces the pin-level waveforms of one byte lane for a single DDR write burst. A write request hands it eight data bytes and eight mask bits at once. It then drives the lane through a fixed sequence. First comes a strobe preamble, held low for one memory clock. Next come eight data beats, one on each rising and falling strobe edge. Then a short postamble holds the strobe low. Finally it releases the lane. The strobe is produced as a true/complement pair and moves only inside the burst.

The internal clock runs at four times the memory clock, so each beat spans two internal cycles. Each data value is presented one internal cycle (a quarter memory clock) before the strobe edge that carries it. The strobe edge therefore lands in the middle of the data window. A single lane output enable frames the whole transaction. The pad buffer uses it to tri-state the strobe pair, data and mask. While the enable is low, every lane value is held at zero. A ready output shows when a new request will be taken. A done pulse marks the cycle in which the lane goes back to high impedance.

Top module: `ddr_wr_strobe_lane`

## Requirements
- R1: `wr_ready` is high exactly while no burst is in progress. A request is taken only on a clock edge where `wr_req` and `wr_ready` are both high. A request, data or mask presented while a burst runs has no effect on that burst.
- R2: Cycle t=0 is the first cycle after the accepting edge. `lane_oe` is high for t=0..21, which is 22 internal cycles, and low otherwise. While it is low, `strobe_t`, `strobe_c`, `dq_out` and `dm_out` are all 0.
- R3: The preamble covers t=0..3. During it, `strobe_t`=0 and `strobe_c`=1. `dq_out`/`dm_out` are 0 for t=0..2.
- R4: The strobe makes exactly 8 transitions, at t=4,6,...,18. The transitions alternate, starting with a rise, so `strobe_t` is 1 for t in 4..19 exactly when (t/2) is even. It does not toggle outside t=4..19.
- R5: Beat k (k=0..7) is data bits [8k+7:8k] and mask bit k. It is presented on `dq_out`/`dm_out` during t=3+2k and t=4+2k. Data never changes in a cycle where the strobe changes, and the strobe never changes where data changes.
- R6: While `lane_oe` is high, `strobe_c` is always the inverse of `strobe_t`.
- R7: The postamble covers t=20..21. During it, `strobe_t`=0 and `dq_out`/`dm_out` are 0. After it, the lane is released.
- R8: `wr_done` is high for exactly one cycle, t=22, which is the first cycle with `lane_oe` low after a burst. It is low at all other times.
- R9: A request presented during the done cycle is accepted, and the next burst's t=0 follows immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, four times the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write burst request |
| wr_data | input | 64 | Eight beats of data, beat k in bits [8k+7:8k] |
| wr_mask | input | 8 | Mask bit per beat, beat k in bit k |
| wr_ready | output | 1 | High when a request will be accepted |
| wr_done | output | 1 | One-cycle pulse when the lane is released |
| lane_oe | output | 1 | Output enable for strobe pair, data and mask pads |
| strobe_t | output | 1 | True strobe |
| strobe_c | output | 1 | Complement strobe |
| dq_out | output | 8 | Data byte of the current beat |
| dm_out | output | 1 | Mask bit of the current beat |

## Verification
Several properties are checked on every cycle: the zero lane outside the enable window, the complement relation of the strobe pair, and the quarter-cycle separation between data changes and strobe edges. The same per-cycle checks cover a low strobe in the preamble and postamble, and the single-cycle done pulse that coincides with release. Counters in the checker confirm that every transaction spans exactly 22 cycles and contains exactly eight strobe transitions. Only the bench scenarios can show that the right byte and mask bit sit in each beat slot, and that requests arriving mid-burst are dropped without disturbing the burst. They also show that a request taken in the done cycle starts the next burst without a gap.

// File: rtl/wrs_pkg.sv
`timescale 1ns/1ps
package wrs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_BURST = 2'd2,
    PH_POST  = 2'd3
  } wr_phase_e;

  typedef logic [15:0] tick_t;

  // True when pos lies in [lo, lo+len)
  function automatic logic in_span(tick_t pos, tick_t lo, tick_t len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // Index of the step-wide slot that pos falls in, counted from lo
  function automatic tick_t slot_of(tick_t pos, tick_t lo, tick_t step);
    return (pos - lo) / step;
  endfunction

  // Strobe is high in even slots: first edge rises
  function automatic logic strobe_high(tick_t t, tick_t lo, tick_t step);
    tick_t s;
    s = slot_of(t, lo, step);
    return ~s[0];
  endfunction

endpackage

// File: rtl/wrs_seq.sv
`timescale 1ns/1ps
module wrs_seq
  import wrs_pkg::*;
#(
  parameter int PRE_CYC   = 4,
  parameter int BURST_CYC = 16,
  parameter int POST_CYC  = 2,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output wr_phase_e     phase,
  output logic [CW-1:0] tick,
  output logic          done_pulse
);

  localparam logic [CW-1:0] PRE_END   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] BURST_END = CW'(PRE_CYC + BURST_CYC - 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(PRE_CYC + BURST_CYC + POST_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      tick       <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_PRE;
          tick  <= '0;
        end
      end else begin
        tick <= tick + 1'b1;
        if (tick == LAST_TICK) begin
          phase      <= PH_IDLE;
          tick       <= '0;
          done_pulse <= 1'b1;
        end else if (tick == PRE_END) begin
          phase <= PH_BURST;
        end else if (tick == BURST_END) begin
          phase <= PH_POST;
        end
      end
    end
  end

endmodule

// File: rtl/wrs_beat_sel.sv
`timescale 1ns/1ps
module wrs_beat_sel
  import wrs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 8,
  parameter int PRE_CYC   = 4,
  parameter int BEAT_CYC  = 2,
  parameter int LEAD      = 1,
  parameter int CW        = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [BURST_LEN*DATA_W-1:0] ld_data,
  input  logic [BURST_LEN-1:0]      ld_mask,
  input  logic                      active,
  input  logic [CW-1:0]             tick,
  output logic [DATA_W-1:0]         beat_byte,
  output logic                      beat_mask
);

  localparam int IW        = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int BURST_CYC = BURST_LEN * BEAT_CYC;

  logic [BURST_LEN*DATA_W-1:0] held_data;
  logic [BURST_LEN-1:0]        held_mask;

  // One holding register per beat, loaded when the request is taken
  for (genvar g = 0; g < BURST_LEN; g++) begin : g_beat
    logic [DATA_W-1:0] byte_q;
    logic              mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        mask_q <= 1'b0;
      end else if (load) begin
        byte_q <= ld_data[g*DATA_W +: DATA_W];
        mask_q <= ld_mask[g];
      end
    end
    assign held_data[g*DATA_W +: DATA_W] = byte_q;
    assign held_mask[g]                  = mask_q;
  end

  // Data runs LEAD cycles ahead of the strobe edge it belongs to
  tick_t          lead_pos;
  tick_t          slot;
  logic           in_window;
  logic [IW-1:0]  idx;

  assign lead_pos  = tick_t'(tick) + tick_t'(LEAD);
  assign in_window = active && in_span(lead_pos, tick_t'(PRE_CYC), tick_t'(BURST_CYC));
  assign slot      = slot_of(lead_pos, tick_t'(PRE_CYC), tick_t'(BEAT_CYC));
  assign idx       = slot[IW-1:0];

  assign beat_byte = in_window ? held_data[idx*DATA_W +: DATA_W] : '0;
  assign beat_mask = in_window ? held_mask[idx] : 1'b0;

endmodule

// File: rtl/wrs_strobe.sv
`timescale 1ns/1ps
module wrs_strobe
  import wrs_pkg::*;
#(
  parameter int PRE_CYC  = 4,
  parameter int BEAT_CYC = 2,
  parameter int CW       = 5
) (
  input  wr_phase_e     phase,
  input  logic [CW-1:0] tick,
  output logic          strobe_t,
  output logic          strobe_c
);

  logic level;

  assign level    = (phase == PH_BURST) &&
                    strobe_high(tick_t'(tick), tick_t'(PRE_CYC), tick_t'(BEAT_CYC));
  assign strobe_t = level;
  assign strobe_c = (phase != PH_IDLE) && !level;

endmodule

// File: rtl/ddr_wr_strobe_lane.sv
`timescale 1ns/1ps
module ddr_wr_strobe_lane
  import wrs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 8,
  parameter int CLK_RATIO = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic [BURST_LEN*DATA_W-1:0] wr_data,
  input  logic [BURST_LEN-1:0]        wr_mask,
  output logic                        wr_ready,
  output logic                        wr_done,
  output logic                        lane_oe,
  output logic                        strobe_t,
  output logic                        strobe_c,
  output logic [DATA_W-1:0]           dq_out,
  output logic                        dm_out
);

  localparam int PRE_CYC   = CLK_RATIO;
  localparam int BEAT_CYC  = CLK_RATIO / 2;
  localparam int LEAD      = CLK_RATIO / 4;
  localparam int POST_CYC  = CLK_RATIO / 2;
  localparam int BURST_CYC = BURST_LEN * BEAT_CYC;
  localparam int TOTAL_CYC = PRE_CYC + BURST_CYC + POST_CYC;
  localparam int CW        = $clog2(TOTAL_CYC + 1);

  wr_phase_e     phase;
  logic [CW-1:0] tick;
  logic          accept;
  logic          busy;

  assign busy     = (phase != PH_IDLE);
  assign wr_ready = !busy;
  assign accept   = wr_req && wr_ready;
  assign lane_oe  = busy;

  wrs_seq #(
    .PRE_CYC  (PRE_CYC),
    .BURST_CYC(BURST_CYC),
    .POST_CYC (POST_CYC),
    .CW       (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .phase     (phase),
    .tick      (tick),
    .done_pulse(wr_done)
  );

  wrs_beat_sel #(
    .DATA_W   (DATA_W),
    .BURST_LEN(BURST_LEN),
    .PRE_CYC  (PRE_CYC),
    .BEAT_CYC (BEAT_CYC),
    .LEAD     (LEAD),
    .CW       (CW)
  ) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_data  (wr_data),
    .ld_mask  (wr_mask),
    .active   (busy),
    .tick     (tick),
    .beat_byte(dq_out),
    .beat_mask(dm_out)
  );

  wrs_strobe #(
    .PRE_CYC (PRE_CYC),
    .BEAT_CYC(BEAT_CYC),
    .CW      (CW)
  ) u_strobe (
    .phase   (phase),
    .tick    (tick),
    .strobe_t(strobe_t),
    .strobe_c(strobe_c)
  );

endmodule

// File: rtl/wrs_chk.sv
`timescale 1ns/1ps
module wrs_chk #(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 8,
  parameter int CLK_RATIO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              wr_ready,
  input logic              wr_done,
  input logic              lane_oe,
  input logic              strobe_t,
  input logic              strobe_c,
  input logic [DATA_W-1:0] dq_out,
  input logic              dm_out
);

  localparam int PRE   = CLK_RATIO;
  localparam int BCYC  = BURST_LEN * (CLK_RATIO / 2);
  localparam int TOTAL = PRE + BCYC + CLK_RATIO / 2;
  localparam int RW    = $clog2(TOTAL + 2) + 1;
  localparam int EW    = $clog2(2 * BURST_LEN + 2) + 1;

  logic [RW-1:0] run;
  logic [EW-1:0] edges;
  logic          prev_t;

  // run = cycles of lane_oe already elapsed; edges = strobe transitions seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      edges  <= '0;
      prev_t <= 1'b0;
    end else begin
      prev_t <= strobe_t;
      if (lane_oe) begin
        run   <= run + 1'b1;
        edges <= edges + EW'(strobe_t != prev_t);
      end else begin
        run   <= '0;
        edges <= '0;
      end
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lane_oe |-> !wr_ready); // R1
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_oe) |-> $past(wr_req)); // R1
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe |-> (!strobe_t && !strobe_c && dq_out == '0 && !dm_out)); // R2
  AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_oe) |-> (run == RW'(TOTAL))); // R2
  AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && run < RW'(PRE)) |-> !strobe_t); // R3
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_oe) |-> (edges == EW'(BURST_LEN))); // R4
  AST_DATA_STILL_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && $past(lane_oe) && strobe_t != $past(strobe_t)) |-> ($stable(dq_out) && $stable(dm_out))); // R5
  AST_STROBE_STILL_AT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && $past(lane_oe) && dq_out != $past(dq_out)) |-> $stable(strobe_t)); // R5
  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    lane_oe |-> (strobe_c == !strobe_t)); // R6
  AST_POSTAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && run >= RW'(PRE + BCYC)) |-> (!strobe_t && dq_out == '0 && !dm_out)); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_oe) |-> wr_done); // R8
  AST_DONE_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!lane_oe && $past(lane_oe))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R8

endmodule

bind ddr_wr_strobe_lane wrs_chk #(
  .DATA_W   (DATA_W),
  .BURST_LEN(BURST_LEN),
  .CLK_RATIO(CLK_RATIO)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_req  (wr_req),
  .wr_ready(wr_ready),
  .wr_done (wr_done),
  .lane_oe (lane_oe),
  .strobe_t(strobe_t),
  .strobe_c(strobe_c),
  .dq_out  (dq_out),
  .dm_out  (dm_out)
);

// File: tb/ddr_wr_strobe_lane_test.sv
`timescale 1ns/1ps
module ddr_wr_strobe_lane_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_mask = '0;
  logic        wr_ready, wr_done, lane_oe, strobe_t, strobe_c, dm_out;
  logic [7:0]  dq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ddr_wr_strobe_lane uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_ready(wr_ready), .wr_done(wr_done),
    .lane_oe(lane_oe), .strobe_t(strobe_t), .strobe_c(strobe_c),
    .dq_out(dq_out), .dm_out(dm_out)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model written from the requirements, t = cycles since start
  function automatic logic ref_strobe(int t);
    if (t < 4 || t > 19) return 1'b0;
    return ((t / 2) % 2) == 0;
  endfunction

  function automatic logic [7:0] ref_byte(int t, logic [63:0] d);
    if (t < 3 || t > 18) return 8'h00;
    return d[((t - 3) / 2) * 8 +: 8];
  endfunction

  function automatic logic ref_mask(int t, logic [7:0] m);
    if (t < 3 || t > 18) return 1'b0;
    return m[(t - 3) / 2];
  endfunction

  // Entered and left at a falling edge with the block idle.
  // poke: keep requesting with other data during the burst (R1).
  // gap: spend one idle cycle after the done cycle.
  task automatic run_burst(logic [63:0] d, logic [7:0] m, bit poke, bit gap);
    string stag;
    check("R1", "ready before request", 64'(wr_ready), 64'd1);
    wr_req  = 1'b1;
    wr_data = d;
    wr_mask = m;
    @(negedge clk);
    if (poke) begin
      wr_data = ~d;
      wr_mask = ~m;
    end else begin
      wr_req = 1'b0;
    end
    for (int t = 0; t < 22; t++) begin
      if (t > 0) @(negedge clk);
      stag = (t < 4) ? "R3" : (t >= 20) ? "R7" : "R4";
      check("R2", "lane_oe in window", 64'(lane_oe), 64'd1);
      check(stag, "strobe_t", 64'(strobe_t), 64'(ref_strobe(t)));
      check("R6", "strobe_c", 64'(strobe_c), 64'(!ref_strobe(t)));
      check((t < 3) ? "R3" : "R5", "dq_out beat", 64'(dq_out), 64'(ref_byte(t, d)));
      check((t < 3) ? "R3" : "R5", "dm_out beat", 64'(dm_out), 64'(ref_mask(t, m)));
      check("R1", "ready while busy", 64'(wr_ready), 64'd0);
      check("R8", "done inside burst", 64'(wr_done), 64'd0);
      if (poke && t == 6) wr_req = 1'b0;
    end
    @(negedge clk);  // t = 22
    check("R2", "lane released", 64'(lane_oe), 64'd0);
    check("R2", "quiet lane", {55'd0, strobe_t, strobe_c, dq_out}, 64'd0);
    check("R8", "done pulse", 64'(wr_done), 64'd1);
    check("R9", "ready in done cycle", 64'(wr_ready), 64'd1);
    if (gap) begin
      @(negedge clk);
      check("R8", "done one cycle only", 64'(wr_done), 64'd0);
      check("R2", "idle lane off", 64'(lane_oe), 64'd0);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [7:0]  rm;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset lane_oe", 64'(lane_oe), 64'd0);
    check("R1", "reset ready", 64'(wr_ready), 64'd1);
    check("R8", "reset done", 64'(wr_done), 64'd0);
    check("R2", "reset quiet", {54'd0, strobe_t, strobe_c, dm_out, dq_out}, 64'd0);

    // Directed corners
    run_burst(64'h0, 8'h00, 1'b0, 1'b1);
    run_burst(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b1);
    run_burst(64'h0123_4567_89AB_CDEF, 8'h5A, 1'b1, 1'b1);  // R1 mid-burst requests
    run_burst(64'hAA55_AA55_AA55_AA55, 8'hA5, 1'b0, 1'b0);
    run_burst(64'h8877_6655_4433_2211, 8'h81, 1'b0, 1'b0);  // R9 back-to-back
    run_burst(64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 1'b1, 1'b1);

    // Constrained random bursts
    for (int i = 0; i < 24; i++) begin
      rd = {$urandom(), $urandom()};
      rm = 8'($urandom());
      run_burst(rd, rm, ($urandom() % 4) == 0, ($urandom() % 2) == 0);
    end

    @(negedge clk);
    check("R8", "final idle done low", 64'(wr_done), 64'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule